// File: doc/BRIEF.md
# Peripheral Chip Select Generator

This block turns a 20-bit bus address into a set of active-low peripheral chip selects. The selects sit in consecutive 256-byte slices above a base that software places on a 2 KB boundary. Slice 4 is a hole and slice 7 is not used, so six of the eight slices in the 2 KB block drive a select. The selects can be placed in memory space or in the 16-bit I/O space. For each access the block also counts a programmed number of wait states before it signals ready to the CPU. Software can require the external ready input to be high as well, or tell the block to ignore it.

Software programs two registers through a small write port. The configuration word holds the base, a wait-state code and a ready-mode bit. The mode register holds a single space-select bit. An access begins when the bus raises a start strobe with a matching address. The matching select then goes low and stays low until ready-to-CPU has been high for one cycle. The select vector is seven bits wide so that each select keeps its slice number as its index. Bit 4 marks the hole and never goes low.

Top module: `pcs_gen`

## Requirements
- R1: After reset, every select output is high and ready-to-CPU is low. Start strobes have no effect until both the configuration word (`reg_wr_sel`=0) and the mode register (`reg_wr_sel`=1) have each been written at least once.
- R2: In memory space (mode bit 0 = 0, `addr_is_io`=0), configuration bits 15:7 are compared with address bits 19:11. Address bits 10:8 values 0, 1, 2 and 3 drive `cs_n[0]`, `cs_n[1]`, `cs_n[2]` and `cs_n[3]` low.
- R3: Address bits 10:8 values 5 and 6 drive `cs_n[5]` and `cs_n[6]`. Slice values 4 and 7, an address outside the 2 KB block, and a mismatch between `addr_is_io` and mode bit 0 all leave every select high, and no access starts.
- R4: With mode bit 0 = 1, only `addr_is_io`=1 accesses match, and they compare address bits 15:11 with configuration bits 11:7. Any I/O match also requires configuration bits 15:12 to be zero.
- R5: For selects 0–3 the wait count comes from the code {bit3, bit1, bit0}. The codes 000 to 111 give 0, 1, 2, 3, 5, 7, 9 and 15 waits.
- R6: For selects 5 and 6 the wait count is bits 1:0 alone (0–3), and bit 3 has no effect.
- R7: When configuration bit 2 is 1, external ready is ignored. Ready-to-CPU first goes high exactly W cycles after the first cycle in which the select is low, where W is the wait count.
- R8: When configuration bit 2 is 0, ready-to-CPU is high only when the count has expired and `ext_rdy` is high. If `ext_rdy` first goes high in cycle D of the access, ready-to-CPU first goes high in cycle max(W, D).
- R9: The select goes low in the cycle after the start strobe and holds through the cycle in which ready-to-CPU is high. It is released on the next cycle. At most one select is low at any time, and a start strobe during an access is ignored.
- R10: `cfg_rd_data` returns the configuration word with bits 6:4 reading as 1 whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0: configuration word, 1: mode register |
| reg_wr_data | input | 16 | Write data |
| cfg_rd_data | output | 16 | Configuration word readback |
| addr | input | 20 | Bus address |
| addr_is_io | input | 1 | Address belongs to I/O space |
| acc_start | input | 1 | Access-start strobe |
| ext_rdy | input | 1 | External ready |
| cs_n | output | 7 | Active-low selects, index = slice number, bit 4 unused |
| rdy_out | output | 1 | Ready to CPU |

## Verification
The hardest case to reach is ready-to-CPU when the wait count and external ready end at different cycles. The bench covers this by holding `ext_rdy` low for a chosen number of cycles per access, both longer and shorter than the programmed count, and timing the first ready cycle. The ignored-restart case needs a second start strobe, with a different matching address, while a long access is still running. The bench then checks that the select and the ready timing do not change. The I/O case whose upper base bits are nonzero is built so that the lower base bits still match, which means only the zero check can reject it.

// File: rtl/pcs_pkg.sv
// Shared constants and the low-select wait-state code table.
// Assumes the slice index is 3 bits wide (eight slices per block).
package pcs_pkg;

    localparam int unsigned NUM_SLICE = 8;
    localparam int unsigned NUM_CS    = 7;
    localparam int unsigned HOLE_IDX  = 4;
    localparam int unsigned CNT_W     = 4;

    // Translates the 3-bit code of selects 0-3 into a wait count.
    function automatic logic [CNT_W-1:0] low_wait(input logic [2:0] code);
        logic [CNT_W-1:0] w;
        case (code)
            3'd0:    w = 4'd0;
            3'd1:    w = 4'd1;
            3'd2:    w = 4'd2;
            3'd3:    w = 4'd3;
            3'd4:    w = 4'd5;
            3'd5:    w = 4'd7;
            3'd6:    w = 4'd9;
            default: w = 4'd15;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pcs_cfg_regs.sv
// Holds the configuration word and the mode bit, and tracks whether each
// register has been written since reset. Assumes one write per cycle.
module pcs_cfg_regs #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg_word,
    output logic              io_mode,
    output logic              cfg_done
);

    logic word_seen;
    logic mode_seen;

    // Captures register writes and records the first write to each register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_word  <= '0;
            io_mode   <= 1'b0;
            word_seen <= 1'b0;
            mode_seen <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel) begin
                io_mode   <= wr_data[0];
                mode_seen <= 1'b1;
            end else begin
                cfg_word  <= wr_data;
                word_seen <= 1'b1;
            end
        end
    end

    // The selects are usable only once both registers have been written.
    always_comb cfg_done = word_seen & mode_seen;

endmodule

// File: rtl/pcs_addr_decode.sv
// Combinational address match: finds the 256-byte slice inside the 2 KB
// block and produces a one-hot select vector. Assumes the I/O space is the
// low IO_W bits of the address.
module pcs_addr_decode #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned IO_W     = 16,
    parameter int unsigned SLICE_W  = 8,
    parameter int unsigned BASE_LSB = SLICE_W + 3,
    parameter int unsigned NUM_CS   = 7,
    localparam int unsigned BASE_W  = ADDR_W - BASE_LSB,
    localparam int unsigned SEL_W   = BASE_LSB - SLICE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_is_io,
    input  logic [BASE_W-1:0] base_hi,
    input  logic              io_mode,
    input  logic              cfg_done,
    output logic [SEL_W-1:0]  slice,
    output logic              hit,
    output logic [NUM_CS-1:0] sel_vec
);

    localparam int unsigned IO_HI_W = ADDR_W - IO_W;
    localparam int unsigned IO_LO_W = IO_W - BASE_LSB;

    logic mem_match;
    logic io_match;
    logic space_ok;
    logic slice_ok;

    // Compares the block address in the active space and rules out the unused slices.
    always_comb begin
        slice     = addr[BASE_LSB-1:SLICE_W];
        space_ok  = (addr_is_io == io_mode);
        mem_match = (addr[ADDR_W-1:BASE_LSB] == base_hi);
        io_match  = (base_hi[BASE_W-1 -: IO_HI_W] == '0) &&
                    (addr[IO_W-1:BASE_LSB] == base_hi[IO_LO_W-1:0]);
        slice_ok  = (slice != SEL_W'(pcs_pkg::HOLE_IDX)) &&
                    (slice != SEL_W'(pcs_pkg::NUM_SLICE - 1));
        hit       = cfg_done && space_ok && slice_ok &&
                    (io_mode ? io_match : mem_match);
    end

    // One select line per slice index; the hole line can never be chosen.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        if (i == pcs_pkg::HOLE_IDX) begin : g_hole
            assign sel_vec[i] = 1'b0;
        end else begin : g_live
            assign sel_vec[i] = hit && (slice == SEL_W'(i));
        end
    end

endmodule

// File: rtl/pcs_wait_ctrl.sv
// Access sequencer: latches the select on a start strobe, counts wait states
// down and raises ready when the count is spent and external ready allows.
// Assumes the start strobe is ignored while an access is in progress.
module pcs_wait_ctrl #(
    parameter int unsigned NUM_CS = 7,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CS-1:0] sel_vec,
    input  logic [CNT_W-1:0]  wait_load,
    input  logic              rdy_ign,
    input  logic              ext_rdy,
    output logic [NUM_CS-1:0] cs_n,
    output logic              rdy_out
);

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [NUM_CS-1:0] cs_q;

    // Starts, counts and ends one access at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            cs_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= wait_load;
                cs_q <= sel_vec;
            end
        end else if (rdy_out) begin
            busy <= 1'b0;
            cs_q <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Ready once the count is spent and, unless ignored, the external ready is high.
    always_comb begin
        rdy_out = busy && (cnt == '0) && (rdy_ign || ext_rdy);
        cs_n    = ~cs_q;
    end

endmodule

// File: rtl/pcs_gen.sv
// Peripheral chip select generator top: register file, address decode and
// wait-state sequencer. Configuration word layout: [15:7] base bits 19:11,
// [6:4] read as 1, [3] wait code high bit, [2] ignore external ready,
// [1:0] wait code low bits. Mode register bit 0 selects I/O space.
module pcs_gen #(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned IO_W    = 16,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] cfg_rd_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_is_io,
    input  logic              acc_start,
    input  logic              ext_rdy,
    output logic [6:0]        cs_n,
    output logic              rdy_out
);

    localparam int unsigned BASE_LSB = SLICE_W + 3;
    localparam int unsigned BASE_W   = ADDR_W - BASE_LSB;
    localparam int unsigned SEL_W    = BASE_LSB - SLICE_W;
    localparam int unsigned NUM_CS   = pcs_pkg::NUM_CS;
    localparam int unsigned CNT_W    = pcs_pkg::CNT_W;
    localparam logic [DATA_W-1:0] RSVD_ONES = DATA_W'(7) << 4;

    logic [DATA_W-1:0] cfg_word;
    logic              io_mode;
    logic              cfg_done;
    logic [BASE_W-1:0] base_hi;
    logic              rdy_ign;
    logic [SEL_W-1:0]  slice;
    logic              hit;
    logic [NUM_CS-1:0] sel_vec;
    logic [CNT_W-1:0]  wait_load;

    pcs_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_wr_sel),
        .wr_data  (reg_wr_data),
        .cfg_word (cfg_word),
        .io_mode  (io_mode),
        .cfg_done (cfg_done)
    );

    // Splits the configuration word into its fields and picks the wait count.
    always_comb begin
        base_hi     = cfg_word[DATA_W-1 -: BASE_W];
        rdy_ign     = cfg_word[2];
        cfg_rd_data = cfg_word | RSVD_ONES;
        if (slice < SEL_W'(4)) begin
            wait_load = pcs_pkg::low_wait({cfg_word[3], cfg_word[1:0]});
        end else begin
            wait_load = CNT_W'(cfg_word[1:0]);
        end
    end

    pcs_addr_decode #(
        .ADDR_W  (ADDR_W),
        .IO_W    (IO_W),
        .SLICE_W (SLICE_W),
        .NUM_CS  (NUM_CS)
    ) u_dec (
        .addr       (addr),
        .addr_is_io (addr_is_io),
        .base_hi    (base_hi),
        .io_mode    (io_mode),
        .cfg_done   (cfg_done),
        .slice      (slice),
        .hit        (hit),
        .sel_vec    (sel_vec)
    );

    pcs_wait_ctrl #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (acc_start && hit),
        .sel_vec   (sel_vec),
        .wait_load (wait_load),
        .rdy_ign   (rdy_ign),
        .ext_rdy   (ext_rdy),
        .cs_n      (cs_n),
        .rdy_out   (rdy_out)
    );

endmodule

// File: rtl/pcs_gen_chk.sv
// Property checker for pcs_gen, attached by bind. Observes ports and the
// configuration state; drives nothing.
module pcs_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] cs_n,
    input logic       rdy_out,
    input logic       ext_rdy,
    input logic       rdy_ign,
    input logic       cfg_done
);

    assert_quiet_until_configured_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (&cs_n && !rdy_out));

    assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_select_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !rdy_out) |=> $stable(cs_n));

    assert_release_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_out |=> &cs_n);

    assert_ready_waits_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_out && !rdy_ign) |-> ext_rdy);

    assert_ready_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_out |-> !(&cs_n));

endmodule

bind pcs_gen pcs_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rdy_out  (rdy_out),
    .ext_rdy  (ext_rdy),
    .rdy_ign  (rdy_ign),
    .cfg_done (cfg_done)
);

// File: tb/pcs_gen_test.sv
`timescale 1ns/1ps
// Directed bench for pcs_gen: one task per scenario, each checking its own results.
module pcs_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] cfg_rd_data;
    logic [19:0] addr = '0;
    logic        addr_is_io = 1'b0;
    logic        acc_start = 1'b0;
    logic        ext_rdy = 1'b0;
    logic [6:0]  cs_n;
    logic        rdy_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcs_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .cfg_rd_data(cfg_rd_data), .addr(addr),
        .addr_is_io(addr_is_io), .acc_start(acc_start), .ext_rdy(ext_rdy),
        .cs_n(cs_n), .rdy_out(rdy_out)
    );

    localparam logic [19:0] MBASE = 20'h48000;

    function automatic logic [15:0] mkcfg(input logic [19:0] base, input logic r3,
                                          input logic ign, input logic [1:0] lo);
        return {base[19:11], 3'b000, r3, ign, lo};
    endfunction

    function automatic int exp_wait(input int idx, input logic r3, input logic [1:0] lo);
        int t[8] = '{0, 1, 2, 3, 5, 7, 9, 15};
        if (idx >= 5) return int'(lo);
        return t[{r3, lo}];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        tick();
        reg_wr_en = 1'b0;
    endtask

    // Runs one access and checks select, ready timing and release.
    task automatic run_access(input string req, input logic [19:0] a, input logic io,
                              input int idx, input int expw, input bit ign,
                              input int rdy_delay, input bit poke);
        int first = -1;
        bit hold_ok = 1'b1;
        logic [6:0] expcs = ~(7'b1 << idx);
        int expr = ign ? expw : ((rdy_delay > expw) ? rdy_delay : expw);
        addr = a; addr_is_io = io; acc_start = 1'b1;
        tick();
        acc_start = 1'b0;
        for (int k = 0; k < 40; k++) begin
            ext_rdy = (k >= rdy_delay);
            if (poke && k == 1) begin
                addr = MBASE + 20'h600; addr_is_io = 1'b0; acc_start = 1'b1;
            end
            if (poke && k == 2) acc_start = 1'b0;
            #1;
            if (cs_n != expcs) hold_ok = 1'b0;
            if (rdy_out) begin
                first = k;
                break;
            end
            tick();
        end
        acc_start = 1'b0;
        check(hold_ok, req, "select during access", cs_n, expcs);
        check(first == expr, req, "first ready cycle", first, expr);
        tick();
        ext_rdy = 1'b0;
        check(cs_n == 7'h7f && !rdy_out, req, "release after ready", cs_n, 7'h7f);
    endtask

    // Pulses a start that must not open an access.
    task automatic run_none(input string req, input logic [19:0] a, input logic io);
        bit ok = 1'b1;
        addr = a; addr_is_io = io; acc_start = 1'b1; ext_rdy = 1'b1;
        tick();
        acc_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (cs_n != 7'h7f || rdy_out) ok = 1'b0;
            tick();
        end
        ext_rdy = 1'b0;
        check(ok, req, "no select expected", cs_n, 7'h7f);
    endtask

    task automatic t_reset();
        check(cs_n == 7'h7f && !rdy_out, "R1", "reset state", cs_n, 7'h7f);
        run_none("R1", 20'h00000, 1'b0);
        wr(1'b0, mkcfg(20'h00000, 1'b0, 1'b1, 2'd0));
        run_none("R1", 20'h00000, 1'b0);
        wr(1'b1, 16'h0000);
        run_access("R1", 20'h00010, 1'b0, 0, 0, 1'b1, 0, 1'b0);
    endtask

    task automatic t_mem_low();
        wr(1'b0, mkcfg(MBASE, 1'b0, 1'b1, 2'd1));
        run_access("R2", MBASE + 20'h000, 1'b0, 0, 1, 1'b1, 0, 1'b0);
        run_access("R2", MBASE + 20'h1ff, 1'b0, 1, 1, 1'b1, 0, 1'b0);
        run_access("R2", MBASE + 20'h200, 1'b0, 2, 1, 1'b1, 0, 1'b0);
        run_access("R2", MBASE + 20'h3ff, 1'b0, 3, 1, 1'b1, 0, 1'b0);
    endtask

    task automatic t_mem_high();
        run_access("R3", MBASE + 20'h500, 1'b0, 5, 1, 1'b1, 0, 1'b0);
        run_access("R3", MBASE + 20'h6ff, 1'b0, 6, 1, 1'b1, 0, 1'b0);
        run_none("R3", MBASE + 20'h400, 1'b0);
        run_none("R3", MBASE + 20'h4ff, 1'b0);
        run_none("R3", MBASE + 20'h700, 1'b0);
        run_none("R3", MBASE + 20'h800, 1'b0);
        run_none("R3", MBASE - 20'h001, 1'b0);
        run_none("R3", MBASE + 20'h100, 1'b1);
    endtask

    task automatic t_wait_codes();
        for (int c = 0; c < 8; c++) begin
            logic r3 = c[2];
            logic [1:0] lo = c[1:0];
            wr(1'b0, mkcfg(MBASE, r3, 1'b1, lo));
            run_access("R5", MBASE + 20'h080, 1'b0, 0, exp_wait(0, r3, lo), 1'b1, 0, 1'b0);
        end
    endtask

    task automatic t_high_waits();
        wr(1'b0, mkcfg(MBASE, 1'b1, 1'b1, 2'd2));
        run_access("R6", MBASE + 20'h500, 1'b0, 5, exp_wait(5, 1'b1, 2'd2), 1'b1, 0, 1'b0);
        wr(1'b0, mkcfg(MBASE, 1'b1, 1'b1, 2'd3));
        run_access("R6", MBASE + 20'h600, 1'b0, 6, exp_wait(6, 1'b1, 2'd3), 1'b1, 0, 1'b0);
        run_access("R6", MBASE + 20'h300, 1'b0, 3, exp_wait(3, 1'b1, 2'd3), 1'b1, 0, 1'b0);
    endtask

    task automatic t_ready_modes();
        wr(1'b0, mkcfg(MBASE, 1'b0, 1'b1, 2'd1));
        run_access("R7", MBASE + 20'h000, 1'b0, 0, 1, 1'b1, 30, 1'b0);
        wr(1'b0, mkcfg(MBASE, 1'b0, 1'b0, 2'd1));
        run_access("R8", MBASE + 20'h000, 1'b0, 0, 1, 1'b0, 6, 1'b0);
        wr(1'b0, mkcfg(MBASE, 1'b0, 1'b0, 2'd3));
        run_access("R8", MBASE + 20'h200, 1'b0, 2, 3, 1'b0, 0, 1'b0);
        run_access("R8", MBASE + 20'h200, 1'b0, 2, 3, 1'b0, 3, 1'b0);
    endtask

    task automatic t_io();
        wr(1'b1, 16'h0001);
        wr(1'b0, mkcfg(20'h0a000, 1'b0, 1'b1, 2'd2));
        run_access("R4", 20'h0a100, 1'b1, 1, 2, 1'b1, 0, 1'b0);
        run_access("R4", 20'hfa500, 1'b1, 5, 2, 1'b1, 0, 1'b0);
        run_none("R4", 20'h0a100, 1'b0);
        wr(1'b0, mkcfg(20'h1a000, 1'b0, 1'b1, 2'd2));
        run_none("R4", 20'h0a100, 1'b1);
        run_none("R4", 20'h1a100, 1'b1);
        wr(1'b1, 16'h0000);
    endtask

    task automatic t_restart_ignored();
        wr(1'b0, mkcfg(MBASE, 1'b1, 1'b1, 2'd1));
        run_access("R9", MBASE + 20'h300, 1'b0, 3, 7, 1'b1, 0, 1'b1);
    endtask

    task automatic t_readback();
        wr(1'b0, 16'h0000);
        #1 check(cfg_rd_data == 16'h0070, "R10", "readback zero", cfg_rd_data, 16'h0070);
        wr(1'b0, 16'h4a8b);
        #1 check(cfg_rd_data == 16'h4afb, "R10", "readback mixed", cfg_rd_data, 16'h4afb);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mem_low();
        t_mem_high();
        t_wait_codes();
        t_high_waits();
        t_ready_modes();
        t_io();
        t_restart_ignored();
        t_readback();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule